// File: doc/BRIEF.md
# Lane-Partitioned Integer Reservation Station

This block is the out-of-order integer scheduler that sits between an in-order dispatch front end and a set of execution lanes. It holds fifteen macro-ops in three independent lanes of five entries. Each lane feeds one ALU and one address-generation unit. Every cycle the front end may hand one macro-op to each lane. A macro-op carries three source slots, and each slot holds either a value or the tag of a result still in flight. Three result buses are watched every cycle, and a waiting slot whose tag appears on one of them captures the broadcast value.

A macro-op expands into an ALU micro-op, an address micro-op, or both. The two micro-ops of an entry issue independently. Inside each lane, the oldest ready ALU micro-op and the oldest ready address micro-op are chosen separately, so one lane can start work from two different entries in the same cycle. A load-op waiting for its memory data never blocks younger work in its lane. An entry frees its slot once every micro-op it owes has issued. A flush input empties every lane at once.

Top module: `int_rsv_station`

## Requirements
- R1: After reset every lane reports it can accept a macro-op, and no ALU or address micro-op is issued.
- R2: A lane holds at most DEPTH macro-ops. While all its entries are in use, its dispatch-ready output is low and a macro-op offered to it is discarded without a trace.
- R3: A macro-op of kind 2'b01 (register to register) issues exactly one ALU micro-op, with operand A taken from slot 0 and operand B from slot 1. It never issues an address micro-op.
- R4: A macro-op of kind 2'b10 (address only) issues exactly one address micro-op, whose base is the value of slot 0, and never an ALU micro-op.
- R5: A macro-op of kind 2'b11 (load-op) issues its address micro-op first, using slot 0. Its ALU micro-op becomes eligible only in a cycle after that issue, and only once slot 1 and slot 2 hold values. Slot 2 is the load data, returned under its tag on a result bus. The ALU micro-op carries slot 2 as operand A and slot 1 as operand B.
- R6: A waiting slot whose tag matches a valid result bus captures that bus's data at the clock edge. If several buses match, the lowest-numbered bus wins. The micro-op that needed the slot can issue in the cycle after the edge.
- R7: A result whose tag is broadcast in the same cycle that a macro-op naming that tag is dispatched wakes the new entry's slot.
- R8: Among the ready micro-ops of one kind in a lane, the one from the entry dispatched earliest is issued.
- R9: In one lane, an ALU micro-op and an address micro-op from different entries can issue in the same cycle. A load-op waiting for its data does not stop younger entries from using the lane's ALU.
- R10: While a lane's unit-free input for ALU (or address) is low, that lane issues no micro-op of that kind, and the waiting entries keep their place.
- R11: An entry is released at the edge where its last owed micro-op issues, and the slot can accept a new macro-op in the next cycle.
- R12: A flush empties every entry at the next edge. A macro-op offered in the flush cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard every entry at the next edge |
| disp_valid | input | LANES | Per-lane dispatch request |
| disp_ready | output | LANES | Per-lane free-entry indication |
| disp_kind | input | 2*LANES | Macro-op kind per lane (01 ALU, 10 address, 11 load-op) |
| disp_id | input | ID_W*LANES | Macro-op identifier returned on issue |
| disp_src_rdy | input | 3*LANES | Per-slot "value present" flags |
| disp_src_tag | input | 3*TAG_W*LANES | Per-slot producer tags |
| disp_src_val | input | 3*DATA_W*LANES | Per-slot values |
| res_valid | input | NBUS | Result bus valid |
| res_tag | input | TAG_W*NBUS | Result bus tag |
| res_data | input | DATA_W*NBUS | Result bus data |
| alu_free | input | LANES | Lane ALU can accept a micro-op this cycle |
| agu_free | input | LANES | Lane address unit can accept a micro-op this cycle |
| alu_issue | output | LANES | ALU micro-op issued |
| alu_id | output | ID_W*LANES | Identifier of the issued ALU micro-op |
| alu_opa | output | DATA_W*LANES | ALU operand A |
| alu_opb | output | DATA_W*LANES | ALU operand B |
| agu_issue | output | LANES | Address micro-op issued |
| agu_id | output | ID_W*LANES | Identifier of the issued address micro-op |
| agu_base | output | DATA_W*LANES | Address base operand |

## Verification
Issue outputs are decoded from stored state and the unit-free inputs. A macro-op sampled at an edge can therefore show up as an issue in the cycle right after that edge. A result broadcast at an edge makes its consumers eligible in the following cycle. An issue consumed at an edge frees the slot, and dispatch-ready reflects that one cycle later. The bench drives stimulus on the falling edge and compares every lane's outputs one nanosecond later against a queue-based model. The model is then advanced with the same inputs the design samples at the next rising edge, so each expected value lines up with the cycle in which the registers ahead of it have updated.

// File: rtl/irs_pkg.sv
package irs_pkg;

   typedef enum logic [1:0] {
      MOP_NONE = 2'b00,
      MOP_ALU  = 2'b01,
      MOP_MEM  = 2'b10,
      MOP_LDOP = 2'b11
   } mop_kind_e;

   localparam int NSRC = 3;

   function automatic logic owes_alu(mop_kind_e k);
      return (k == MOP_ALU) || (k == MOP_LDOP);
   endfunction

   function automatic logic owes_agu(mop_kind_e k);
      return (k == MOP_MEM) || (k == MOP_LDOP);
   endfunction

endpackage

// File: rtl/irs_oldest_pick.sv
module irs_oldest_pick #(
   parameter int N = 5
) (
   input  logic [N-1:0]   req,
   input  logic [N*N-1:0] older,
   output logic [N-1:0]   pick
);

   always_comb begin
      for (int i = 0; i < N; i++) begin
         pick[i] = req[i];
         for (int j = 0; j < N; j++) begin
            if (j != i && req[j] && older[j*N+i]) pick[i] = 1'b0;
         end
      end
   end

endmodule

// File: rtl/irs_entry.sv
module irs_entry
   import irs_pkg::*;
#(
   parameter int TAG_W  = 7,
   parameter int DATA_W = 16,
   parameter int ID_W   = 6,
   parameter int NBUS   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     wr_en,
   input  logic [1:0]               wr_kind,
   input  logic [ID_W-1:0]          wr_id,
   input  logic [NSRC-1:0]          wr_rdy,
   input  logic [NSRC*TAG_W-1:0]    wr_tag,
   input  logic [NSRC*DATA_W-1:0]   wr_val,
   input  logic [NBUS-1:0]          res_valid,
   input  logic [NBUS*TAG_W-1:0]    res_tag,
   input  logic [NBUS*DATA_W-1:0]   res_data,
   input  logic                     alu_gnt,
   input  logic                     agu_gnt,
   output logic                     vld,
   output logic                     alu_req,
   output logic                     agu_req,
   output logic [ID_W-1:0]          id,
   output logic [DATA_W-1:0]        alu_a,
   output logic [DATA_W-1:0]        alu_b,
   output logic [DATA_W-1:0]        agu_b
);

   mop_kind_e                   kind_q;
   logic                        alu_done, agu_done;
   logic [NSRC-1:0]             rdy_q, rdy_d;
   logic [NSRC-1:0][TAG_W-1:0]  tag_q, tag_d;
   logic [NSRC-1:0][DATA_W-1:0] val_q, val_d;

   // slot wakeup: lowest-numbered matching bus wins
   for (genvar s = 0; s < NSRC; s++) begin : g_slot
      logic              src_rdy, hit;
      logic [TAG_W-1:0]  src_tag;
      logic [DATA_W-1:0] src_val, hit_val;
      always_comb begin
         src_rdy = wr_en ? wr_rdy[s] : rdy_q[s];
         src_tag = wr_en ? wr_tag[s*TAG_W +: TAG_W] : tag_q[s];
         src_val = wr_en ? wr_val[s*DATA_W +: DATA_W] : val_q[s];
         hit     = 1'b0;
         hit_val = '0;
         for (int b = NBUS-1; b >= 0; b--) begin
            if (res_valid[b] && res_tag[b*TAG_W +: TAG_W] == src_tag) begin
               hit     = 1'b1;
               hit_val = res_data[b*DATA_W +: DATA_W];
            end
         end
         rdy_d[s] = src_rdy | hit;
         tag_d[s] = src_tag;
         val_d[s] = (!src_rdy && hit) ? hit_val : src_val;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q <= '0;
         tag_q <= '0;
         val_q <= '0;
      end else begin
         rdy_q <= rdy_d;
         tag_q <= tag_d;
         val_q <= val_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         vld      <= 1'b0;
         alu_done <= 1'b1;
         agu_done <= 1'b1;
         kind_q   <= MOP_NONE;
         id       <= '0;
      end else if (wr_en) begin
         vld      <= 1'b1;
         kind_q   <= mop_kind_e'(wr_kind);
         id       <= wr_id;
         alu_done <= !owes_alu(mop_kind_e'(wr_kind));
         agu_done <= !owes_agu(mop_kind_e'(wr_kind));
      end else if (vld) begin
         alu_done <= alu_done | alu_gnt;
         agu_done <= agu_done | agu_gnt;
         if ((alu_done | alu_gnt) && (agu_done | agu_gnt)) vld <= 1'b0;
      end
   end

   always_comb begin
      if (kind_q == MOP_LDOP)
         alu_req = vld && !alu_done && agu_done && rdy_q[1] && rdy_q[2];
      else
         alu_req = vld && !alu_done && rdy_q[0] && rdy_q[1];
      agu_req = vld && !agu_done && rdy_q[0];
      alu_a   = (kind_q == MOP_LDOP) ? val_q[2] : val_q[0];
      alu_b   = val_q[1];
      agu_b   = val_q[0];
   end

   // R5: a load-op ALU micro-op only goes after its address micro-op went
   a_r5_alu_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && kind_q == MOP_LDOP && alu_gnt) |-> agu_done);

   // R3: a register-to-register entry never drives the address unit
   a_r3_regreg_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && kind_q == MOP_ALU) |-> !agu_gnt);

   // R6: a waiting slot 0 seeing its tag on bus 0 holds a value next cycle
   a_r6_slot0_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !wr_en && !rdy_q[0] && res_valid[0] &&
       res_tag[TAG_W-1:0] == tag_q[0]) |=> rdy_q[0]);

endmodule

// File: rtl/irs_lane.sv
module irs_lane
   import irs_pkg::*;
#(
   parameter int DEPTH  = 5,
   parameter int TAG_W  = 7,
   parameter int DATA_W = 16,
   parameter int ID_W   = 6,
   parameter int NBUS   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     disp_valid,
   output logic                     disp_ready,
   input  logic [1:0]               disp_kind,
   input  logic [ID_W-1:0]          disp_id,
   input  logic [NSRC-1:0]          disp_src_rdy,
   input  logic [NSRC*TAG_W-1:0]    disp_src_tag,
   input  logic [NSRC*DATA_W-1:0]   disp_src_val,
   input  logic [NBUS-1:0]          res_valid,
   input  logic [NBUS*TAG_W-1:0]    res_tag,
   input  logic [NBUS*DATA_W-1:0]   res_data,
   input  logic                     alu_free,
   input  logic                     agu_free,
   output logic                     alu_issue,
   output logic [ID_W-1:0]          alu_id,
   output logic [DATA_W-1:0]        alu_opa,
   output logic [DATA_W-1:0]        alu_opb,
   output logic                     agu_issue,
   output logic [ID_W-1:0]          agu_id,
   output logic [DATA_W-1:0]        agu_base
);

   localparam int AGE_BITS = DEPTH * DEPTH;

   logic [DEPTH-1:0]             vld, alu_req, agu_req, alu_pick, agu_pick;
   logic [DEPTH-1:0]             alu_gnt, agu_gnt, wr_vec;
   logic [DEPTH-1:0][ID_W-1:0]   e_id;
   logic [DEPTH-1:0][DATA_W-1:0] e_alu_a, e_alu_b, e_agu_b;
   logic [AGE_BITS-1:0]          older_q;   // [k*DEPTH+j]: k dispatched before j

   // lowest free slot takes the incoming macro-op
   always_comb begin
      logic found;
      found  = 1'b0;
      wr_vec = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!vld[i] && !found) begin
            wr_vec[i] = disp_valid;
            found     = 1'b1;
         end
      end
      disp_ready = ~&vld;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         older_q <= '0;
      end else if (!flush) begin
         for (int k = 0; k < DEPTH; k++) begin
            if (wr_vec[k]) begin
               for (int j = 0; j < DEPTH; j++) begin
                  older_q[k*DEPTH+j] <= 1'b0;
                  older_q[j*DEPTH+k] <= vld[j];
               end
            end
         end
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      irs_entry #(
         .TAG_W (TAG_W), .DATA_W(DATA_W), .ID_W(ID_W), .NBUS(NBUS)
      ) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .flush    (flush),
         .wr_en    (wr_vec[e]),
         .wr_kind  (disp_kind),
         .wr_id    (disp_id),
         .wr_rdy   (disp_src_rdy),
         .wr_tag   (disp_src_tag),
         .wr_val   (disp_src_val),
         .res_valid(res_valid),
         .res_tag  (res_tag),
         .res_data (res_data),
         .alu_gnt  (alu_gnt[e]),
         .agu_gnt  (agu_gnt[e]),
         .vld      (vld[e]),
         .alu_req  (alu_req[e]),
         .agu_req  (agu_req[e]),
         .id       (e_id[e]),
         .alu_a    (e_alu_a[e]),
         .alu_b    (e_alu_b[e]),
         .agu_b    (e_agu_b[e])
      );
   end

   irs_oldest_pick #(.N(DEPTH)) u_alu_pick (
      .req(alu_req), .older(older_q), .pick(alu_pick));
   irs_oldest_pick #(.N(DEPTH)) u_agu_pick (
      .req(agu_req), .older(older_q), .pick(agu_pick));

   always_comb begin
      alu_gnt   = alu_pick & {DEPTH{alu_free}};
      agu_gnt   = agu_pick & {DEPTH{agu_free}};
      alu_issue = |alu_gnt;
      agu_issue = |agu_gnt;
      alu_id    = '0;
      alu_opa   = '0;
      alu_opb   = '0;
      agu_id    = '0;
      agu_base  = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (alu_pick[e]) begin
            alu_id  = alu_id  | e_id[e];
            alu_opa = alu_opa | e_alu_a[e];
            alu_opb = alu_opb | e_alu_b[e];
         end
         if (agu_pick[e]) begin
            agu_id   = agu_id   | e_id[e];
            agu_base = agu_base | e_agu_b[e];
         end
      end
   end

   // R2: a new macro-op only lands in an unused slot
   a_r2_write_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_vec & vld) == '0);
   // R8: at most one ALU and one address grant per lane
   a_r8_one_alu: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(alu_gnt));
   a_r8_one_agu: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(agu_gnt));
   // R9: same-cycle ALU and address grants come from different entries
   a_r9_split_entries: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_gnt & agu_gnt) == '0);
   // R10: busy units receive nothing
   a_r10_alu_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !alu_free |-> alu_gnt == '0);
   a_r10_agu_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !agu_free |-> agu_gnt == '0);
   // R11: grants only go to entries that asked
   a_r11_grant_has_req: assert property (@(posedge clk) disable iff (!rst_n)
      ((alu_gnt & ~alu_req) | (agu_gnt & ~agu_req)) == '0);
   // R12: flush empties the lane
   a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> vld == '0);

endmodule

// File: rtl/int_rsv_station.sv
module int_rsv_station #(
   parameter int LANES  = 3,
   parameter int DEPTH  = 5,
   parameter int NBUS   = 3,
   parameter int TAG_W  = 7,
   parameter int DATA_W = 16,
   parameter int ID_W   = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic [LANES-1:0]              disp_valid,
   output logic [LANES-1:0]              disp_ready,
   input  logic [2*LANES-1:0]            disp_kind,
   input  logic [ID_W*LANES-1:0]         disp_id,
   input  logic [3*LANES-1:0]            disp_src_rdy,
   input  logic [3*TAG_W*LANES-1:0]      disp_src_tag,
   input  logic [3*DATA_W*LANES-1:0]     disp_src_val,
   input  logic [NBUS-1:0]               res_valid,
   input  logic [TAG_W*NBUS-1:0]         res_tag,
   input  logic [DATA_W*NBUS-1:0]        res_data,
   input  logic [LANES-1:0]              alu_free,
   input  logic [LANES-1:0]              agu_free,
   output logic [LANES-1:0]              alu_issue,
   output logic [ID_W*LANES-1:0]         alu_id,
   output logic [DATA_W*LANES-1:0]       alu_opa,
   output logic [DATA_W*LANES-1:0]       alu_opb,
   output logic [LANES-1:0]              agu_issue,
   output logic [ID_W*LANES-1:0]         agu_id,
   output logic [DATA_W*LANES-1:0]       agu_base
);

   localparam int SRC_TAG_W = 3 * TAG_W;
   localparam int SRC_VAL_W = 3 * DATA_W;

   if (LANES < 1 || DEPTH < 2 || NBUS < 1 || TAG_W < 1 || DATA_W < 1 || ID_W < 1) begin : g_bad_cfg
      $error("int_rsv_station: illegal parameter set");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      irs_lane #(
         .DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .ID_W(ID_W), .NBUS(NBUS)
      ) u_lane (
         .clk         (clk),
         .rst_n       (rst_n),
         .flush       (flush),
         .disp_valid  (disp_valid[l]),
         .disp_ready  (disp_ready[l]),
         .disp_kind   (disp_kind[2*l +: 2]),
         .disp_id     (disp_id[ID_W*l +: ID_W]),
         .disp_src_rdy(disp_src_rdy[3*l +: 3]),
         .disp_src_tag(disp_src_tag[SRC_TAG_W*l +: SRC_TAG_W]),
         .disp_src_val(disp_src_val[SRC_VAL_W*l +: SRC_VAL_W]),
         .res_valid   (res_valid),
         .res_tag     (res_tag),
         .res_data    (res_data),
         .alu_free    (alu_free[l]),
         .agu_free    (agu_free[l]),
         .alu_issue   (alu_issue[l]),
         .alu_id      (alu_id[ID_W*l +: ID_W]),
         .alu_opa     (alu_opa[DATA_W*l +: DATA_W]),
         .alu_opb     (alu_opb[DATA_W*l +: DATA_W]),
         .agu_issue   (agu_issue[l]),
         .agu_id      (agu_id[ID_W*l +: ID_W]),
         .agu_base    (agu_base[DATA_W*l +: DATA_W])
      );
   end

endmodule

// File: tb/int_rsv_station_tb.sv
`timescale 1ns/1ps
module int_rsv_station_tb;

   localparam int NL = 3, DEPTH = 5, NBUS = 3, TAG_W = 7, DATA_W = 16, ID_W = 6;

   logic clk = 1'b0;
   logic rst_n, flush;
   logic [NL-1:0]             disp_valid, disp_ready, alu_free, agu_free, alu_issue, agu_issue;
   logic [2*NL-1:0]           disp_kind;
   logic [ID_W*NL-1:0]        disp_id, alu_id, agu_id;
   logic [3*NL-1:0]           disp_src_rdy;
   logic [3*TAG_W*NL-1:0]     disp_src_tag;
   logic [3*DATA_W*NL-1:0]    disp_src_val;
   logic [NBUS-1:0]           res_valid;
   logic [TAG_W*NBUS-1:0]     res_tag;
   logic [DATA_W*NBUS-1:0]    res_data;
   logic [DATA_W*NL-1:0]      alu_opa, alu_opb, agu_base;

   always #2 clk = ~clk;

   int_rsv_station #(.LANES(NL), .DEPTH(DEPTH), .NBUS(NBUS), .TAG_W(TAG_W),
                     .DATA_W(DATA_W), .ID_W(ID_W)) u_dut (.*);

   int    checks = 0, errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   typedef struct packed {
      logic [1:0]                  kind;
      logic [ID_W-1:0]             id;
      logic [2:0]                  r;
      logic [2:0][TAG_W-1:0]       tg;
      logic [2:0][DATA_W-1:0]      vl;
      logic                        ad;
      logic                        gd;
   } m_ent;

   m_ent lq[NL][$];

   function automatic bit alu_ok(m_ent e);
      if (e.ad) return 1'b0;
      if (e.kind == 2'd1) return e.r[0] && e.r[1];
      return e.kind == 2'd3 && e.gd && e.r[1] && e.r[2];
   endfunction

   function automatic bit agu_ok(m_ent e);
      return !e.gd && e.r[0];
   endfunction

   function automatic int find_alu(int l);
      for (int i = 0; i < lq[l].size(); i++) if (alu_ok(lq[l][i])) return i;
      return -1;
   endfunction

   function automatic int find_agu(int l);
      for (int i = 0; i < lq[l].size(); i++) if (agu_ok(lq[l][i])) return i;
      return -1;
   endfunction

   function automatic m_ent wake(m_ent e);
      for (int s = 0; s < 3; s++) begin
         if (!e.r[s]) begin
            for (int b = 0; b < NBUS; b++) begin
               if (!e.r[s] && res_valid[b] && res_tag[b*TAG_W +: TAG_W] == e.tg[s]) begin
                  e.r[s]  = 1'b1;
                  e.vl[s] = res_data[b*DATA_W +: DATA_W];
               end
            end
         end
      end
      return e;
   endfunction

   task automatic check(string what, int l, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s lane %0d %s: got %0d expected %0d", cur_req, l, what, got, exp);
      end
   endtask

   task automatic compare();
      for (int l = 0; l < NL; l++) begin
         int ai, gi;
         bit ea, eg;
         ai = find_alu(l);
         gi = find_agu(l);
         ea = (ai >= 0) && alu_free[l];
         eg = (gi >= 0) && agu_free[l];
         check("disp_ready", l, disp_ready[l], lq[l].size() < DEPTH);
         check("alu_issue", l, alu_issue[l], ea);
         check("agu_issue", l, agu_issue[l], eg);
         if (ea && alu_issue[l]) begin
            m_ent e;
            e = lq[l][ai];
            check("alu_id", l, alu_id[l*ID_W +: ID_W], e.id);
            check("alu_opa", l, alu_opa[l*DATA_W +: DATA_W], (e.kind == 2'd3) ? e.vl[2] : e.vl[0]);
            check("alu_opb", l, alu_opb[l*DATA_W +: DATA_W], e.vl[1]);
         end
         if (eg && agu_issue[l]) begin
            check("agu_id", l, agu_id[l*ID_W +: ID_W], lq[l][gi].id);
            check("agu_base", l, agu_base[l*DATA_W +: DATA_W], lq[l][gi].vl[0]);
         end
      end
   endtask

   task automatic model_step();
      for (int l = 0; l < NL; l++) begin
         if (!rst_n || flush) begin
            lq[l].delete();
         end else begin
            int   cnt_pre, ai, gi;
            m_ent t;
            m_ent keep[$];
            cnt_pre = lq[l].size();
            ai = find_alu(l);
            gi = find_agu(l);
            if (ai >= 0 && alu_free[l]) begin t = lq[l][ai]; t.ad = 1'b1; lq[l][ai] = t; end
            if (gi >= 0 && agu_free[l]) begin t = lq[l][gi]; t.gd = 1'b1; lq[l][gi] = t; end
            foreach (lq[l][i]) begin
               t = wake(lq[l][i]);
               if (!(t.ad && t.gd)) keep.push_back(t);
            end
            lq[l] = keep;
            if (disp_valid[l] && cnt_pre < DEPTH) begin
               t.kind = disp_kind[l*2 +: 2];
               t.id   = disp_id[l*ID_W +: ID_W];
               t.r    = disp_src_rdy[l*3 +: 3];
               for (int s = 0; s < 3; s++) begin
                  t.tg[s] = disp_src_tag[(l*3+s)*TAG_W +: TAG_W];
                  t.vl[s] = disp_src_val[(l*3+s)*DATA_W +: DATA_W];
               end
               t.ad = !(t.kind == 2'd1 || t.kind == 2'd3);
               t.gd = !(t.kind == 2'd2 || t.kind == 2'd3);
               lq[l].push_back(wake(t));
            end
         end
      end
   endtask

   task automatic idle();
      flush = 1'b0; disp_valid = '0; disp_kind = '0; disp_id = '0;
      disp_src_rdy = '0; disp_src_tag = '0; disp_src_val = '0;
      res_valid = '0; res_tag = '0; res_data = '0;
      alu_free = '1; agu_free = '1;
   endtask

   task automatic put(int l, int k, int id, bit [2:0] rdy, int t0, int t1, int t2,
                      int v0, int v1, int v2);
      disp_valid[l] = 1'b1;
      disp_kind[l*2 +: 2] = k[1:0];
      disp_id[l*ID_W +: ID_W] = id[ID_W-1:0];
      disp_src_rdy[l*3 +: 3] = rdy;
      disp_src_tag[(l*3+0)*TAG_W +: TAG_W] = t0[TAG_W-1:0];
      disp_src_tag[(l*3+1)*TAG_W +: TAG_W] = t1[TAG_W-1:0];
      disp_src_tag[(l*3+2)*TAG_W +: TAG_W] = t2[TAG_W-1:0];
      disp_src_val[(l*3+0)*DATA_W +: DATA_W] = v0[DATA_W-1:0];
      disp_src_val[(l*3+1)*DATA_W +: DATA_W] = v1[DATA_W-1:0];
      disp_src_val[(l*3+2)*DATA_W +: DATA_W] = v2[DATA_W-1:0];
   endtask

   task automatic bus(int b, int t, int d);
      res_valid[b] = 1'b1;
      res_tag[b*TAG_W +: TAG_W] = t[TAG_W-1:0];
      res_data[b*DATA_W +: DATA_W] = d[DATA_W-1:0];
   endtask

   task automatic tick();
      #1;
      compare();
      model_step();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      cur_req = "R1";
      tick();
      rst_n = 1'b1;
      ticks(2);

      cur_req = "R3";
      put(0, 1, 1, 3'b111, 0, 0, 0, 10, 11, 0); ticks(3);

      cur_req = "R4";
      put(1, 2, 2, 3'b001, 0, 0, 0, 20, 0, 0); ticks(3);

      cur_req = "R5";
      put(2, 3, 3, 3'b011, 0, 0, 20, 30, 31, 0); tick();
      cur_req = "R9";
      put(2, 1, 4, 3'b111, 0, 0, 0, 40, 41, 0); ticks(3);
      cur_req = "R5";
      bus(0, 20, 99); ticks(3);

      cur_req = "R6";
      put(0, 1, 5, 3'b101, 0, 30, 0, 50, 0, 0); ticks(3);
      bus(1, 30, 77); bus(2, 30, 88); ticks(3);

      cur_req = "R7";
      put(1, 1, 6, 3'b110, 40, 0, 0, 0, 61, 0); bus(2, 40, 55); ticks(3);

      cur_req = "R8";
      for (int i = 0; i < 3; i++) begin
         put(0, 1, 7 + i, 3'b010, 50, 0, 0, 0, 100 + i, 0); tick();
      end
      bus(0, 50, 5); ticks(5);

      cur_req = "R10";
      put(1, 1, 10, 3'b111, 0, 0, 0, 70, 71, 0);
      put(2, 2, 11, 3'b001, 0, 0, 0, 72, 0, 0); tick();
      for (int i = 0; i < 3; i++) begin
         alu_free[1] = 1'b0; agu_free[2] = 1'b0; tick();
      end
      ticks(2);

      cur_req = "R2";
      for (int i = 0; i < 7; i++) begin
         put(1, 2, 12 + i, 3'b000, 60, 0, 0, 0, 0, 0); tick();
      end

      cur_req = "R11";
      bus(1, 60, 9); tick();
      ticks(7);
      put(1, 1, 21, 3'b111, 0, 0, 0, 80, 81, 0); ticks(3);

      cur_req = "R12";
      put(0, 1, 22, 3'b000, 70, 71, 0, 0, 0, 0);
      put(2, 3, 23, 3'b000, 72, 73, 74, 0, 0, 0); tick();
      flush = 1'b1; put(1, 1, 24, 3'b111, 0, 0, 0, 1, 2, 0); tick();
      bus(0, 70, 1); bus(1, 71, 2); bus(2, 72, 3); tick();
      ticks(3);

      cur_req = "R8";
      for (int c = 0; c < 3000; c++) begin
         int r;
         for (int l = 0; l < NL; l++) begin
            if ($urandom % 3 != 0)
               put(l, 1 + $urandom % 3, $urandom % 64, 3'($urandom % 8),
                   $urandom % 16, $urandom % 16, $urandom % 16,
                   $urandom, $urandom, $urandom);
            alu_free[l] = ($urandom % 4) != 0;
            agu_free[l] = ($urandom % 4) != 0;
         end
         r = $urandom % 16;
         for (int b = 0; b < NBUS; b++)
            if ($urandom % 2) bus(b, (r + b * 5) % 16, $urandom);
         flush = ($urandom % 200) == 0;
         tick();
      end

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule